// File: doc/BRIEF.md
# Square-Wave Pin Controller

This block turns one control byte into the drive of an open-drain output pin. The byte carries three fields: a static pin level, an enable for the square wave and a two-bit rate code. With the wave disabled, the pin simply holds the static level. With the wave enabled, the pin copies one tap of the shared timekeeping divider. The divider counts half-periods of the 32.768 kHz oscillator, so its bits are binary fractions of that frequency. The block also registers a one-cycle marker on every falling edge of the divider's top bit. That edge is the one-second step of the timekeeper, so the 1 Hz waveform falls in the same cycle the seconds advance.

The control is a two-state machine. `MODE_LEVEL` drives the stored level. `MODE_WAVE` drives the selected tap. Reset enters `MODE_LEVEL`. A control write with the enable bit set takes transition T_ENABLE into `MODE_WAVE`. A write with it clear takes T_DISABLE back to `MODE_LEVEL`. Any other write keeps the current state. While the halt input is high, the divider is frozen, and in `MODE_WAVE` the pin keeps its present level.

Top module: `sqw_pin_ctrl`

## Requirements
- R1: After reset, `ctl_rd` reads 8'h03: level 0, wave disabled, rate code 11. `pin_lvl` is 0, `pin_oe` is 1 and `sec_edge` is 0.
- R2: A write stores the level at bit 7, the enable at bit 4 and the rate code at bits 1:0. These bits read back from the next cycle on. Bits 6, 5, 3 and 2 always read 0.
- R3: When `ctl_rd` bit 4 is 0, `pin_lvl` equals the stored bit 7, one cycle after the write. This holds whatever the rate code, the divider taps and the halt input are.
- R4: With the wave enabled and halt low, `pin_lvl` equals the selected tap of `div_taps` as sampled one cycle earlier. The taps are: code 00 uses bit 15 (1 Hz), code 01 uses bit 3 (4.096 kHz), code 10 uses bit 2 (8.192 kHz) and code 11 uses bit 0 (32.768 kHz).
- R5: A new rate code written while the wave runs selects the new tap from the next cycle on. There is no restart and no realignment of the waveform.
- R6: `pin_oe` is 1 (pull low) exactly when `pin_lvl` is 0. Otherwise the pin is released.
- R7: While halt is high, an enabled wave holds `pin_lvl` even if the taps change, and `sec_edge` stays 0.
- R8: `sec_edge` pulses for one cycle after `div_taps` bit 15 is seen 1 and then 0, with halt low. In 1 Hz mode the pulse coincides with the falling edge of `pin_lvl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wd | input | 8 | Control byte write data |
| ctl_rd | output | 8 | Control byte read value |
| div_taps | input | DIV_W (16) | Shared divider state, bit 0 toggles at 32.768 kHz |
| halt | input | 1 | Divider frozen flag |
| pin_oe | output | 1 | Open-drain pull-low enable |
| pin_lvl | output | 1 | Pin level for checking |
| sec_edge | output | 1 | Seconds-advance marker |

## Verification
The bench targets each rate code, including a rate change in the middle of a running wave. A mux wired to the wrong tap, or one that waits for a phase boundary, would show the wrong pin level right after the write. It writes all-ones and reserved-only bytes. A design that stored reserved bits, or that let the level field leak into wave mode, would read back or drive the wrong value. It freezes the enable while flipping the taps under halt, including across a fall of the top bit. A design that ignored halt would move the pin or raise a spurious seconds marker. A full 1 Hz period is run so that the marker and the falling pin edge must land in the same cycle.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    localparam int CTL_W   = 8;
    localparam int BIT_LVL = 7;
    localparam int BIT_EN  = 4;
    localparam int RS_W    = 2;
    localparam int NUM_RATES = 1 << RS_W;

    // bits kept by the byte register (enable lives in the mode state)
    localparam logic [CTL_W-1:0] KEEP_MASK = (CTL_W'(1) << BIT_LVL) | CTL_W'((1 << RS_W) - 1);

    localparam logic            LVL_RESET  = 1'b0;
    localparam logic [RS_W-1:0] RSEL_RESET = '1;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_WAVE  = 1'b1
    } sqw_mode_e;

    typedef struct packed {
        logic            lvl;
        logic [RS_W-1:0] rsel;
    } sqw_cfg_t;

    // log2 of the output frequency in Hz for each rate code
    function automatic int unsigned rate_log2(int unsigned code);
        unique case (code)
            0:       return 0;
            1:       return 12;
            2:       return 13;
            default: return 15;
        endcase
    endfunction

    // divider bit k toggles every 2^k half-periods of the base clock
    function automatic int unsigned rate_tap(int unsigned code, int unsigned div_w);
        return div_w - 1 - rate_log2(code);
    endfunction

endpackage

// File: rtl/sqw_ctl_reg.sv
module sqw_ctl_reg
    import sqw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wd,
    output logic [CTL_W-1:0] stored,
    output sqw_cfg_t         cfg
);

    logic [CTL_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q          <= '0;
            byte_q[BIT_LVL] <= LVL_RESET;
            byte_q[RS_W-1:0] <= RSEL_RESET;
        end else if (we) begin
            byte_q <= wd & KEEP_MASK;
        end
    end

    assign stored   = byte_q;
    assign cfg.lvl  = byte_q[BIT_LVL];
    assign cfg.rsel = byte_q[RS_W-1:0];

endmodule

// File: rtl/sqw_rate_mux.sv
module sqw_rate_mux
    import sqw_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] taps,
    input  logic [RS_W-1:0]  rsel,
    output logic             wave
);

    logic [NUM_RATES-1:0] cand;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int unsigned TAP = rate_tap(g, DIV_W);
        assign cand[g] = taps[TAP];
    end

    assign wave = cand[rsel];

endmodule

// File: rtl/sqw_tick_mark.sv
module sqw_tick_mark (
    input  logic clk,
    input  logic rst_n,
    input  logic top_tap,
    input  logic halt,
    output logic sec_edge
);

    logic tap_q;
    logic mark_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q  <= 1'b0;
            mark_q <= 1'b0;
        end else begin
            mark_q <= !halt && tap_q && !top_tap;
            if (!halt) begin
                tap_q <= top_tap;
            end
        end
    end

    assign sec_edge = mark_q;

endmodule

// File: rtl/sqw_pin_ctrl.sv
module sqw_pin_ctrl
    import sqw_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wd,
    output logic [7:0]       ctl_rd,
    input  logic [DIV_W-1:0] div_taps,
    input  logic             halt,
    output logic             pin_oe,
    output logic             pin_lvl,
    output logic             sec_edge
);

    sqw_cfg_t         cfg;
    logic [CTL_W-1:0] stored;
    logic             wave;
    sqw_mode_e        mode_q;
    sqw_mode_e        mode_d;
    logic             pin_q;

    sqw_ctl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .wd     (ctl_wd),
        .stored (stored),
        .cfg    (cfg)
    );

    sqw_rate_mux #(.DIV_W(DIV_W)) u_mux (
        .taps (div_taps),
        .rsel (cfg.rsel),
        .wave (wave)
    );

    sqw_tick_mark u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .top_tap  (div_taps[DIV_W-1]),
        .halt     (halt),
        .sec_edge (sec_edge)
    );

    // transitions: T_ENABLE / T_DISABLE on a control write
    always_comb begin
        mode_d = mode_q;
        if (ctl_we) begin
            unique case (ctl_wd[BIT_EN])
                1'b1: mode_d = MODE_WAVE;
                1'b0: mode_d = MODE_LEVEL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LEVEL;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= LVL_RESET;
        end else begin
            unique case (mode_q)
                MODE_LEVEL: pin_q <= cfg.lvl;
                MODE_WAVE: begin
                    if (!halt) begin
                        pin_q <= wave;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl_rd         = stored;
        ctl_rd[BIT_EN] = (mode_q == MODE_WAVE);
    end

    assign pin_lvl = pin_q;
    assign pin_oe  = ~pin_q;

endmodule

// File: rtl/sqw_pin_ctrl_chk.sv
module sqw_pin_ctrl_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic [7:0]       ctl_rd,
    input logic [DIV_W-1:0] div_taps,
    input logic             pin_lvl,
    input logic             sec_edge
);

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctl_rd == 8'h03) else $error("reset value"); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd & 8'h6C) == 8'h00) else $error("reserved bits"); // R2

    AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_rd[4]) |-> pin_lvl == $past(ctl_rd[7])) else $error("static level"); // R3

    AST_ONE_HZ_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_rd[4:0]) == 5'h10 && !$past(halt)) |-> pin_lvl == $past(div_taps[DIV_W-1]))
        else $error("1 Hz tap"); // R4

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt) && $past(ctl_rd[4])) |-> $stable(pin_lvl)) else $error("halt hold"); // R7

    AST_NO_MARK_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        sec_edge |-> !$past(halt)) else $error("mark under halt"); // R7

    AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_edge |=> !sec_edge) else $error("mark width"); // R8

endmodule

bind sqw_pin_ctrl sqw_pin_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .ctl_rd   (ctl_rd),
    .div_taps (div_taps),
    .pin_lvl  (pin_lvl),
    .sec_edge (sec_edge)
);

// File: tb/sqw_pin_ctrl_bench.sv
`timescale 1ns/1ps
module sqw_pin_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wd = 8'h00;
    logic        halt = 1'b0;
    logic [15:0] cnt = 16'h0000;
    logic [7:0]  ctl_rd;
    logic        pin_oe, pin_lvl, sec_edge;

    always #4 clk = ~clk;

    sqw_pin_ctrl u_sqw_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
        .ctl_rd(ctl_rd), .div_taps(cnt), .halt(halt),
        .pin_oe(pin_oe), .pin_lvl(pin_lvl), .sec_edge(sec_edge)
    );

    int    checks = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // behavioural reference state
    bit       m_lvl = 0, m_en = 0, m_pin = 0, m_tq = 0, m_sec = 0;
    bit [1:0] m_rs = 2'b11;

    function automatic int tap_of(bit [1:0] rs);
        case (rs)
            2'b00:   return 15;
            2'b01:   return 3;
            2'b10:   return 2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit np, ns, nt;
        if (!rst_n) begin
            m_lvl = 0; m_en = 0; m_rs = 2'b11; m_pin = 0; m_tq = 0; m_sec = 0;
        end else begin
            np = m_en ? (halt ? m_pin : cnt[tap_of(m_rs)]) : m_lvl;
            ns = !halt && m_tq && !cnt[15];
            nt = halt ? m_tq : cnt[15];
            if (ctl_we) begin
                m_lvl = ctl_wd[7]; m_en = ctl_wd[4]; m_rs = ctl_wd[1:0];
            end
            m_pin = np; m_sec = ns; m_tq = nt;
        end
    end

    task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic cyc(bit we, bit [7:0] d, int adv);
        @(negedge clk);
        chk(tag, ctl_rd, {m_lvl, 2'b00, m_en, 2'b00, m_rs});
        chk(tag, {7'd0, pin_lvl}, {7'd0, m_pin});
        chk(tag, {7'd0, sec_edge}, {7'd0, m_sec});
        chk("R6", {7'd0, pin_oe}, {7'd0, !m_pin});
        ctl_we = we;
        ctl_wd = d;
        if (!halt) cnt = cnt + adv[15:0];
    endtask

    initial begin
        int  marks;
        bit  prev;
        // R1 reset state
        repeat (3) cyc(0, 8'h00, 1);
        rst_n = 1'b1;
        chk("R1", ctl_rd, 8'h03);
        chk("R1", {7'd0, pin_oe}, 8'h01);
        chk("R1", {7'd0, pin_lvl}, 8'h00);
        cyc(0, 8'h00, 1);
        chk("R1", ctl_rd, 8'h03);

        // R2 field storage and reserved bits
        tag = "R2";
        cyc(1, 8'hFF, 1); cyc(0, 8'h00, 1); cyc(0, 8'h00, 1);
        chk("R2", ctl_rd, 8'h93);
        cyc(1, 8'h6C, 1); cyc(0, 8'h00, 1); cyc(0, 8'h00, 1);
        chk("R2", ctl_rd, 8'h00);

        // R3 static level, taps moving, also under halt
        tag = "R3";
        cyc(1, 8'h80, 1);
        for (int i = 0; i < 20; i++) cyc(0, 8'h00, $urandom_range(1, 300));
        chk("R3", {7'd0, pin_lvl}, 8'h01);
        cyc(1, 8'h03, 1);
        for (int i = 0; i < 20; i++) cyc(0, 8'h00, $urandom_range(1, 300));
        chk("R3", {7'd0, pin_lvl}, 8'h00);
        halt = 1'b1;
        cyc(1, 8'h81, 0);
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0);
        chk("R3", {7'd0, pin_lvl}, 8'h01);
        cyc(1, 8'h01, 0);
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0);
        halt = 1'b0;

        // R4 every rate code
        tag = "R4";
        for (int rs = 0; rs < 4; rs++) begin
            if (rs == 0) cnt = 16'h7FF0;
            cyc(1, 8'h10 | 8'(rs), 1);
            for (int i = 0; i < 80; i++) cyc(0, 8'h00, 1);
        end

        // R5 rate changes on the fly
        tag = "R5";
        cyc(1, 8'h13, 1);
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1);
        cyc(1, 8'h11, 1);
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1);
        cyc(1, 8'h92, 1);
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1);
        cyc(1, 8'h13, 1);
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1);

        // R7 halt freezes an enabled wave and the marker
        tag = "R7";
        halt = 1'b1;
        for (int i = 0; i < 12; i++) begin
            cnt = cnt ^ 16'hFFFF;
            cyc(0, 8'h00, 0);
        end
        halt = 1'b0;
        cyc(1, 8'h10, 1);
        cnt = 16'hFFF8;
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1);
        halt = 1'b1;
        cnt = 16'h0000;
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 0);
        chk("R7", {7'd0, sec_edge}, 8'h00);
        halt = 1'b0;
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 1);

        // R8 a full 1 Hz period: one marker, aligned with pin fall
        tag = "R8";
        cyc(1, 8'h10, 1);
        cnt = 16'h0000;
        marks = 0;
        prev = pin_lvl;
        for (int i = 0; i < 66000; i++) begin
            cyc(0, 8'h00, 1);
            if (sec_edge) marks++;
            if (prev && !pin_lvl) chk("R8", {7'd0, sec_edge}, 8'h01);
            prev = pin_lvl;
        end
        chk("R8", 8'(marks), 8'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule